// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit is a 32-bit execute-stage datapath that clamps results instead of letting them wrap. It offers five arithmetic operations: signed add, signed subtract, signed doubling, unsigned add and unsigned subtract. A sixth operation is a plain add that returns the wrapped sum but still reports signed overflow. The unit also limits a value to a programmable bit width, either as one 32-bit word or as two independent 16-bit halves, in signed or unsigned form.

The result is combinational from the operands, the operation select and the width. Any saturation reported by an issued operation is captured in a registered, sticky overflow flag. That flag drops only through an explicit clear input. The surrounding pipeline decides when an operation is issued and when to sample the result.

Top module: `sat_alu`

## Requirements
- R1: Op code 0 (signed add) returns a+b. Overflow means the operands share a sign and the sum's sign differs from a's sign. On overflow the result is 0x7FFFFFFF when a is non-negative and 0x80000000 when a is negative, and saturation is reported.
- R2: Op code 1 (signed subtract) returns a-b. Overflow means the operands differ in sign and the difference's sign differs from a's sign. The clamp values are the same as in R1, and saturation is reported.
- R3: Op code 3 (flagging add) always returns the wrapped sum a+b. It reports saturation under the R1 overflow rule.
- R4: Op code 2 (signed doubling) returns 0x7FFFFFFF when a is at least 0x40000000, and 0x80000000 when a is at most 0xC0000000 (signed). Both cases report saturation. Otherwise it returns a shifted left by one.
- R5: Op code 4 (unsigned add) returns 0xFFFFFFFF with saturation when a+b carries out of 32 bits. Op code 5 (unsigned subtract) returns 0 with saturation when b exceeds a. Otherwise they return the plain sum or difference.
- R6: Op code 6 (signed width limit, width field w from 0 to 31) passes a unchanged when it lies in [-2^w, 2^w-1]. Otherwise it returns the nearer bound and reports saturation.
- R7: Op code 7 (unsigned width limit, width w) returns 0 for negative a and 2^w-1 for a above 2^w-1, reporting saturation in both cases. Otherwise it passes a unchanged.
- R8: Op codes 8 and 9 apply R6 and R7 respectively to bits 15:0 and 31:16. Each half is taken as a sign-extended 16-bit value. The two 16-bit results are packed back into the same halves, and saturation is reported if either half clamps.
- R9: An operation issued with opEn high that reports saturation sets qFlag at the next clock edge. qFlag then stays set through any number of non-saturating operations.
- R10: qClear clears qFlag at the next edge. When a saturating operation is issued in the same cycle as qClear, qFlag ends up set.
- R11: Op codes 10 to 15 are reserved: they give result 0. Reserved codes, and any operation with opEn low, leave qFlag unchanged.
- R12: While rstN is low, qFlag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opEn | input | 1 | An operation is issued this cycle |
| opSel | input | 4 | Operation code |
| opA | input | 32 | First operand, or value to be width-limited |
| opB | input | 32 | Second operand |
| satWidth | input | 5 | Width parameter w for the width-limit operations |
| qClear | input | 1 | Clear the sticky flag |
| result | output | 32 | Combinational result |
| qFlag | output | 1 | Sticky saturation flag |

## Verification
The hardest situations to reach from the ports are the exact clamp boundaries. Examples are doubling 0xC0000000, a sum that lands exactly on 0x80000000, and a halfword that clamps while its neighbour passes. Random operands almost never hit these. The stimulus therefore crosses every operation with every pair drawn from a list of boundary values (0x7FFFFFFF, 0x80000000, 0x40000000, 0xC0000000 and their neighbours) before a long random run. Directed sequences then place a clear and a saturating operation in the same cycle, to reach the flag priority case.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SDBL   = 4'd2,
    OP_WRAPQ  = 4'd3,
    OP_UADD   = 4'd4,
    OP_USUB   = 4'd5,
    OP_SSAT   = 4'd6,
    OP_USAT   = 4'd7,
    OP_SSAT16 = 4'd8,
    OP_USAT16 = 4'd9
  } sat_op_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic legal;
    logic selSAdd;
    logic selSSub;
    logic selDbl;
    logic selWrap;
    logic selUAdd;
    logic selUSub;
    logic selWidth;
    logic widthSigned;
    logic dual;
  } dp_ctrl_t;

endpackage

// File: rtl/sat_clamp.sv
`timescale 1ns/1ps
// Limits a sign-extended value to [-2^w, 2^w-1] (signed) or [0, 2^w-1] (unsigned)
module sat_clamp #(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] valIn,
  input  logic [SHW-1:0]    width,
  input  logic              isSigned,
  output logic [OUT_W-1:0]  valOut,
  output logic              hit
);
  logic [DATA_W-1:0] limit;
  logic tooHigh, tooLow;

  assign limit = (DATA_W'(1) << width) - DATA_W'(1);

  always_comb begin
    if (isSigned) begin
      tooHigh = $signed(valIn) > $signed(limit);
      tooLow  = $signed(valIn) < $signed(~limit);
    end else begin
      tooLow  = valIn[DATA_W-1];
      tooHigh = !valIn[DATA_W-1] && (valIn > limit);
    end
    if (tooHigh)
      valOut = limit[OUT_W-1:0];
    else if (tooLow)
      valOut = isSigned ? ~(limit[OUT_W-1:0]) : '0;
    else
      valOut = valIn[OUT_W-1:0];
    hit = tooHigh || tooLow;
  end
endmodule

// File: rtl/sat_datapath.sv
`timescale 1ns/1ps
module sat_datapath
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 2,
  localparam int LANE_W = DATA_W / LANES,
  localparam int SHW    = $clog2(DATA_W)
) (
  input  dp_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SHW-1:0]    width,
  output logic [DATA_W-1:0] result,
  output logic              satHit
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff, dblVal, clampS;
  logic [DATA_W:0]   uSum;
  logic              addOvf, subOvf, dblHi, dblLo, uBorrow;
  logic [DATA_W-1:0] wordOut;
  logic              wordHit;
  logic [DATA_W-1:0] laneOut;
  logic [LANES-1:0]  laneHit;

  assign sum     = opA + opB;
  assign diff    = opA - opB;
  assign uSum    = {1'b0, opA} + {1'b0, opB};
  assign uBorrow = opB > opA;
  assign addOvf  = (sum[MSB] ^ opA[MSB]) & ~(opA[MSB] ^ opB[MSB]);
  assign subOvf  = (diff[MSB] ^ opA[MSB]) & (opA[MSB] ^ opB[MSB]);
  assign clampS  = opA[MSB] ? MIN_NEG : MAX_POS;
  assign dblHi   = !opA[MSB] && opA[MSB-1];
  assign dblLo   = opA[MSB] && (!opA[MSB-1] || (opA[MSB-2:0] == '0));
  assign dblVal  = {opA[MSB-1:0], 1'b0};

  sat_clamp #(.DATA_W(DATA_W), .OUT_W(DATA_W)) u_word (
    .valIn(opA), .width(width), .isSigned(ctrl.widthSigned),
    .valOut(wordOut), .hit(wordHit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] laneIn;
    assign laneIn = {{(DATA_W-LANE_W){opA[(g+1)*LANE_W-1]}}, opA[g*LANE_W +: LANE_W]};
    sat_clamp #(.DATA_W(DATA_W), .OUT_W(LANE_W)) u_lane (
      .valIn(laneIn), .width(width), .isSigned(ctrl.widthSigned),
      .valOut(laneOut[g*LANE_W +: LANE_W]), .hit(laneHit[g])
    );
  end

  always_comb begin
    result = '0;
    satHit = 1'b0;
    if (ctrl.legal) begin
      if (ctrl.selSAdd) begin
        result = addOvf ? clampS : sum;
        satHit = addOvf;
      end else if (ctrl.selSSub) begin
        result = subOvf ? clampS : diff;
        satHit = subOvf;
      end else if (ctrl.selWrap) begin
        result = sum;
        satHit = addOvf;
      end else if (ctrl.selDbl) begin
        result = dblHi ? MAX_POS : (dblLo ? MIN_NEG : dblVal);
        satHit = dblHi || dblLo;
      end else if (ctrl.selUAdd) begin
        result = uSum[DATA_W] ? '1 : uSum[DATA_W-1:0];
        satHit = uSum[DATA_W];
      end else if (ctrl.selUSub) begin
        result = uBorrow ? '0 : diff;
        satHit = uBorrow;
      end else if (ctrl.selWidth) begin
        result = ctrl.dual ? laneOut : wordOut;
        satHit = ctrl.dual ? |laneHit : wordHit;
      end
    end
  end
endmodule

// File: rtl/sat_control.sv
`timescale 1ns/1ps
module sat_control
  import sat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opEn,
  input  logic [3:0] opSel,
  input  logic       qClear,
  input  logic       satHit,
  output dp_ctrl_t   ctrl,
  output logic       qFlag
);
  sat_op_e op;
  logic    qSet;

  assign op = sat_op_e'(opSel);

  always_comb begin
    ctrl = '0;
    ctrl.legal = 1'b1;
    case (op)
      OP_SADD:   ctrl.selSAdd = 1'b1;
      OP_SSUB:   ctrl.selSSub = 1'b1;
      OP_SDBL:   ctrl.selDbl  = 1'b1;
      OP_WRAPQ:  ctrl.selWrap = 1'b1;
      OP_UADD:   ctrl.selUAdd = 1'b1;
      OP_USUB:   ctrl.selUSub = 1'b1;
      OP_SSAT:   begin ctrl.selWidth = 1'b1; ctrl.widthSigned = 1'b1; end
      OP_USAT:   ctrl.selWidth = 1'b1;
      OP_SSAT16: begin ctrl.selWidth = 1'b1; ctrl.widthSigned = 1'b1; ctrl.dual = 1'b1; end
      OP_USAT16: begin ctrl.selWidth = 1'b1; ctrl.dual = 1'b1; end
      default:   ctrl.legal = 1'b0;
    endcase
  end

  assign qSet = opEn && ctrl.legal && satHit;

  always_ff @(posedge clk) begin
    if (!rstN)       qFlag <= 1'b0;
    else if (qSet)   qFlag <= 1'b1;
    else if (qClear) qFlag <= 1'b0;
  end

  // R9: an issued saturating op sets the flag
  p_q_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opEn && satHit && opSel <= 4'd9) |=> qFlag);
  // R9: flag is sticky without a clear
  p_q_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (qFlag && !qClear) |=> qFlag);
  // R10: clear without saturation drops the flag
  p_q_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (qClear && !(opEn && satHit)) |=> !qFlag);
  // R11: idle cycles keep the flag
  p_q_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!opEn && !qClear) |=> $stable(qFlag));
endmodule

// File: rtl/sat_alu.sv
`timescale 1ns/1ps
module sat_alu
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opEn,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SHW-1:0]    satWidth,
  input  logic              qClear,
  output logic [DATA_W-1:0] result,
  output logic              qFlag
);
  dp_ctrl_t ctrl;
  logic     satHit;

  sat_control u_ctrl (
    .clk(clk), .rstN(rstN), .opEn(opEn), .opSel(opSel),
    .qClear(qClear), .satHit(satHit), .ctrl(ctrl), .qFlag(qFlag)
  );

  sat_datapath #(.DATA_W(DATA_W), .LANES(2)) u_dp (
    .ctrl(ctrl), .opA(opA), .opB(opB), .width(satWidth),
    .result(result), .satHit(satHit)
  );

  // R5: unsigned add never lands below a, unsigned subtract never above a
  p_uadd_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd4) |-> (result >= opA));
  p_usub_ceiling_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd5) |-> (result <= opA));
  // R4: doubling keeps the operand's sign
  p_dbl_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd2) |-> (result[DATA_W-1] == opA[DATA_W-1]));
  // R11: reserved codes give zero
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opSel > 4'd9) |-> (result == '0));
endmodule

// File: tb/sim_sat_alu.sv
`timescale 1ns/1ps
module sim_sat_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opEn = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  satWidth = '0;
  logic        qClear = 1'b0;
  logic [31:0] result;
  logic        qFlag;

  always #2 clk = ~clk;

  sat_alu u0 (
    .clk(clk), .rstN(rstN), .opEn(opEn), .opSel(opSel), .opA(opA), .opB(opB),
    .satWidth(satWidth), .qClear(qClear), .result(result), .qFlag(qFlag)
  );

  typedef struct {
    logic [31:0] expRes;
    logic        expQ;
    string       tag;
    logic [3:0]  op;
    logic [31:0] a;
  } item_t;

  item_t sbq[$];
  int    vectors = 0;
  int    miscompares = 0;
  logic  qModel = 1'b0;
  bit    done = 1'b0;

  logic [31:0] edges[9] = '{32'h7FFFFFFF, 32'h80000000, 32'h40000000, 32'hC0000000,
                            32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h3FFFFFFF,
                            32'hC0000001};

  function automatic logic [32:0] sRef(longint v, int w);
    longint lim = longint'(1) << w;
    if (v > lim - 1) return {1'b1, 32'(lim - 1)};
    if (v < -lim)    return {1'b1, 32'(-lim)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] uRef(longint v, int w);
    longint lim = longint'(1) << w;
    if (v < 0)       return {1'b1, 32'h0};
    if (v > lim - 1) return {1'b1, 32'(lim - 1)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] refOp(logic [3:0] op, logic [31:0] a, logic [31:0] b, int w);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'h0, a});
    longint ub = longint'({32'h0, b});
    longint s;
    logic [32:0] lo, hi;
    case (op)
      4'd0, 4'd3: begin
        s = sa + sb;
        if (s > 64'sd2147483647 || s < -64'sd2147483648)
          return {1'b1, (op == 4'd3) ? a + b : (a[31] ? 32'h80000000 : 32'h7FFFFFFF)};
        return {1'b0, a + b};
      end
      4'd1: begin
        s = sa - sb;
        if (s > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
        if (s < -64'sd2147483648) return {1'b1, 32'h80000000};
        return {1'b0, a - b};
      end
      4'd2: begin
        if (sa >= 64'sd1073741824)  return {1'b1, 32'h7FFFFFFF};
        if (sa <= -64'sd1073741824) return {1'b1, 32'h80000000};
        return {1'b0, 32'(sa * 2)};
      end
      4'd4: return (ua + ub > 64'hFFFFFFFF) ? {1'b1, 32'hFFFFFFFF} : {1'b0, a + b};
      4'd5: return (ub > ua) ? {1'b1, 32'h0} : {1'b0, a - b};
      4'd6: return sRef(sa, w);
      4'd7: return uRef(sa, w);
      4'd8, 4'd9: begin
        if (op == 4'd8) begin
          lo = sRef(longint'($signed(a[15:0])), w);
          hi = sRef(longint'($signed(a[31:16])), w);
        end else begin
          lo = uRef(longint'($signed(a[15:0])), w);
          hi = uRef(longint'($signed(a[31:16])), w);
        end
        return {lo[32] | hi[32], hi[15:0], lo[15:0]};
      end
      default: return 33'h0;
    endcase
  endfunction

  function automatic string opTag(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R4";
      4'd3: return "R3";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Driver: applies one vector and pushes its expectation
  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b, int w,
                       logic en, logic clr, string tag);
    logic [32:0] r;
    item_t it;
    @(posedge clk);
    #1;
    opSel = op; opA = a; opB = b; satWidth = 5'(w); opEn = en; qClear = clr;
    r = refOp(op, a, b, w);
    it.expRes = r[31:0];
    it.expQ   = qModel;
    it.tag    = tag;
    it.op     = op;
    it.a      = a;
    sbq.push_back(it);
    if (en && op <= 4'd9 && r[32]) qModel = 1'b1;
    else if (clr)                  qModel = 1'b0;
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      vectors++;
      if (result !== it.expRes) begin
        miscompares++;
        $display("FAIL %s op=%0d a=%h result actual=%h expected=%h", it.tag, it.op, it.a, result, it.expRes);
      end
      if (qFlag !== it.expQ) begin
        miscompares++;
        $display("FAIL %s op=%0d qFlag actual=%b expected=%b", it.tag, it.op, qFlag, it.expQ);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R12: flag is 0 out of reset
    apply(4'd0, 32'd1, 32'd2, 0, 1'b0, 1'b0, "R12");

    // Directed boundaries, each with a clear so the flag tracks one op
    apply(4'd0, 32'h7FFFFFFF, 32'h1, 0, 1, 1, "R1");
    apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 0, 1, 1, "R1");
    apply(4'd0, 32'd5, 32'd7, 0, 1, 1, "R1");
    apply(4'd1, 32'h80000000, 32'h1, 0, 1, 1, "R2");
    apply(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1, 1, "R2");
    apply(4'd1, 32'h0, 32'h80000000, 0, 1, 1, "R2");
    apply(4'd3, 32'h7FFFFFFF, 32'h1, 0, 1, 1, "R3");
    apply(4'd3, 32'd10, 32'hFFFFFFFF, 0, 1, 1, "R3");
    apply(4'd2, 32'h40000000, 0, 0, 1, 1, "R4");
    apply(4'd2, 32'h3FFFFFFF, 0, 0, 1, 1, "R4");
    apply(4'd2, 32'hC0000000, 0, 0, 1, 1, "R4");
    apply(4'd2, 32'hC0000001, 0, 0, 1, 1, "R4");
    apply(4'd4, 32'hFFFFFFFF, 32'h1, 0, 1, 1, "R5");
    apply(4'd5, 32'd3, 32'd5, 0, 1, 1, "R5");
    apply(4'd5, 32'd5, 32'd5, 0, 1, 1, "R5");
    apply(4'd6, 32'd200, 0, 7, 1, 1, "R6");
    apply(4'd6, -32'sd200, 0, 7, 1, 1, "R6");
    apply(4'd6, 32'd100, 0, 7, 1, 1, "R6");
    apply(4'd6, 32'h80000000, 0, 31, 1, 1, "R6");
    apply(4'd7, 32'hFFFFFFFF, 0, 8, 1, 1, "R7");
    apply(4'd7, 32'd300, 0, 8, 1, 1, "R7");
    apply(4'd7, 32'd1, 0, 0, 1, 1, "R7");
    apply(4'd7, 32'd0, 0, 0, 1, 1, "R7");
    apply(4'd8, 32'h80007FFF, 0, 7, 1, 1, "R8");
    apply(4'd8, 32'h00050003, 0, 7, 1, 1, "R8");
    apply(4'd9, 32'hFFFF0020, 0, 4, 1, 1, "R8");

    // R9: sticky through non-saturating ops
    apply(4'd0, 32'd1, 32'd1, 0, 1, 1, "R9");
    apply(4'd4, 32'hFFFFFFFF, 32'h2, 0, 1, 0, "R9");
    apply(4'd0, 32'd1, 32'd1, 0, 1, 0, "R9");
    apply(4'd6, 32'd3, 0, 4, 1, 0, "R9");
    apply(4'd5, 32'd9, 32'd1, 0, 1, 0, "R9");
    // R10: clear alone, then clear with saturation
    apply(4'd0, 32'd1, 32'd1, 0, 0, 1, "R10");
    apply(4'd5, 32'd0, 32'd1, 0, 1, 1, "R10");
    apply(4'd0, 32'd1, 32'd1, 0, 0, 1, "R10");
    // R11: unissued saturating op and reserved codes leave the flag
    apply(4'd4, 32'hFFFFFFFF, 32'h1, 0, 0, 0, "R11");
    apply(4'd12, 32'h7FFFFFFF, 32'h1, 5, 1, 0, "R11");
    apply(4'd15, 32'h80000000, 32'h7, 3, 1, 0, "R11");
    apply(4'd0, 32'd2, 32'd2, 0, 0, 0, "R11");

    // Every op across every pair of boundary values
    for (int op = 0; op < 10; op++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          apply(4'(op), edges[i], edges[j], (i * 4 + j) % 32, 1, (j == 0), opTag(4'(op)));

    // Random run, mixing boundary values into the operands
    for (int k = 0; k < 4000; k++) begin
      logic [3:0]  op = 4'($urandom_range(0, 11));
      logic [31:0] a = ($urandom_range(0, 1) == 0) ? edges[$urandom_range(0, 8)] : $urandom();
      logic [31:0] b = ($urandom_range(0, 1) == 0) ? edges[$urandom_range(0, 8)] : $urandom();
      apply(op, a, b, $urandom_range(0, 31), ($urandom_range(0, 9) != 0),
            ($urandom_range(0, 15) == 0), opTag(op));
    end

    @(posedge clk);
    #1 opEn = 1'b0; qClear = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule